// File: doc/BRIEF.md
# Two-Strike Timeout Watchdog Timer

A countdown watchdog for a system controller. The counter counts down on each `tick_i` pulse. When it runs out, it reloads from a programmable period and records the event in a sticky expire flag. The system reset output is raised only when the counter runs out a second time while that flag is still set. Two expiries in a row with no service are therefore needed before the system is reset. With a period of P ticks, the time from a hang to reset is between a little over P and 2P ticks, depending on where in the interval the hang happened.

After reset the block starts in auto-clear mode. In this mode every expiry is absorbed by a management-interrupt path that keeps the flag clear, so healthy firmware keeps the system alive until software takes over. Software arms the real watchdog by clearing the auto-clear bit. It disarms the watchdog by setting the bit again. Software services the timer by writing the keepalive register, which reloads the count and clears the flag. It can also clear only the flag through the status register.

Register map (4-bit byte offset, 16-bit data):

| Offset | Write effect | Read value |
|---|---|---|
| 0x0 | keepalive (data ignored) | current count |
| 0x4 | expire flag, bit 3, write-one-to-clear | expire flag in bit 3 |
| 0x8 | auto-clear enable in bit 13 | auto-clear enable in bit 13 |
| 0xC | period in bits 9:0 | period in bits 9:0 |

Top module: `wdt2_top`

## Requirements
- R1: After synchronous reset, the expire flag is 0 and `sys_rst_o` is low. The control register reads 0x2000 (auto-clear on). The period register and the count both read the default period of 20.
- R2: Each clock with `tick_i` high and no keepalive decrements the count read at offset 0x0. A clock without a tick leaves the count unchanged.
- R3: A tick when the count is 1 (or 0) is an expiry. The count reloads from the period register. If auto-clear is off, the expire flag (bit 3 at offset 0x4) is set on the same clock edge.
- R4: An expiry while the expire flag is already set and auto-clear is off raises `sys_rst_o`. The output stays high for exactly RST_HOLD clocks (default 8) and is then released.
- R5: Writing offset 0x4 with bit 3 = 1 clears the expire flag. Writing it with bit 3 = 0 leaves the flag unchanged.
- R6: A write to offset 0x0 reloads the count from the period register and clears the expire flag. It takes priority over a tick in the same clock, so no expiry occurs.
- R7: While bit 13 of the control register (offset 0x8) is 1, an expiry leaves the expire flag clear and never raises `sys_rst_o`.
- R8: A write to the period register (offset 0xC, 10 bits) does not change the running count. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| srst_i | input | 1 | Synchronous reset, active high |
| reg_wr_i | input | 1 | Register write strobe, one clock per write |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i`, combinational |
| tick_i | input | 1 | Countdown tick, one clock per pulse |
| sys_rst_o | output | 1 | System reset request, held for RST_HOLD clocks |

## Verification
The assertions assume that a register write lasts exactly one clock and that `tick_i` is synchronous to the clock. They also assume a keepalive and a status clear are never mistaken for each other, because they use different offsets. The stimulus drives every write and tick for one cycle from the falling edge and never holds `reg_wr_i` across two edges. It reaches the flag and reset states only through the documented register port and the tick input.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFS_KICK = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_PER  = 4'hC;

    localparam int FLAG_BIT = 3;
    localparam int ACLR_BIT = 13;
endpackage

// File: rtl/wdt2_regs.sv
module wdt2_regs
    import wdt2_pkg::*;
#(
    parameter int PERIOD_W = 10,
    parameter logic [PERIOD_W-1:0] DEF_PERIOD = 20,
    parameter logic ACLR_INIT = 1'b1
) (
    input  logic                clk_i,
    input  logic                srst_i,
    input  logic                wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [PERIOD_W-1:0] count_i,
    input  logic                flag_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [PERIOD_W-1:0] period_o,
    output logic                aclr_o,
    output logic                kick_o,
    output logic                clear_o
);
    localparam int PAD_W = DATA_W - PERIOD_W;

    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic                aclr;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && addr_i == OFS_PER) begin
            st_d.period = wdata_i[PERIOD_W-1:0];
        end
        if (wr_i && addr_i == OFS_CTRL) begin
            st_d.aclr = wdata_i[ACLR_BIT];
        end
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            st_q.period <= DEF_PERIOD;
            st_q.aclr   <= ACLR_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        kick_o  = wr_i && (addr_i == OFS_KICK);
        clear_o = kick_o || (wr_i && (addr_i == OFS_STAT) && wdata_i[FLAG_BIT]);
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_KICK: rdata_o = {{PAD_W{1'b0}}, count_i};
            OFS_STAT: rdata_o[FLAG_BIT] = flag_i;
            OFS_CTRL: rdata_o[ACLR_BIT] = st_q.aclr;
            OFS_PER:  rdata_o = {{PAD_W{1'b0}}, st_q.period};
            default:  rdata_o = '0;
        endcase
    end

    assign period_o = st_q.period;
    assign aclr_o   = st_q.aclr;

    AST_CTRL_HOLDS: assert property (@(posedge clk_i) disable iff (srst_i)
        !(wr_i && addr_i == OFS_CTRL) |=> $stable(aclr_o));  // R7
    AST_PERIOD_HOLDS: assert property (@(posedge clk_i) disable iff (srst_i)
        !(wr_i && addr_i == OFS_PER) |=> $stable(period_o));  // R8
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
    parameter int PERIOD_W = 10,
    parameter logic [PERIOD_W-1:0] DEF_PERIOD = 20
) (
    input  logic                clk_i,
    input  logic                srst_i,
    input  logic                tick_i,
    input  logic                reload_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic [PERIOD_W-1:0] count_o,
    output logic                expire_o
);
    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic last_step;

    always_comb begin
        st_d      = st_q;
        last_step = (st_q.cnt <= ONE);
        expire_o  = 1'b0;
        if (reload_i) begin
            st_d.cnt = period_i;
        end else if (tick_i) begin
            if (last_step) begin
                st_d.cnt = period_i;
                expire_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            st_q.cnt <= DEF_PERIOD;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

    AST_COUNT_IDLE: assert property (@(posedge clk_i) disable iff (srst_i)
        (!tick_i && !reload_i) |=> $stable(count_o));  // R2
    AST_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (srst_i)
        expire_o |=> (count_o == $past(period_i)));  // R3
    AST_KICK_NO_EXPIRE: assert property (@(posedge clk_i) disable iff (srst_i)
        reload_i |-> !expire_o);  // R6
endmodule

// File: rtl/wdt2_strike.sv
module wdt2_strike #(
    parameter int RST_HOLD = 8
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic expire_i,
    input  logic aclr_i,
    input  logic clear_i,
    output logic flag_o,
    output logic rst_o
);
    localparam int HOLD_W = $clog2(RST_HOLD + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(RST_HOLD);

    typedef struct packed {
        logic              flag;
        logic [HOLD_W-1:0] hold;
    } strike_t;

    strike_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - HOLD_W'(1);
        end
        if (clear_i) begin
            st_d.flag = 1'b0;
        end
        if (expire_i) begin
            if (aclr_i) begin
                st_d.flag = 1'b0;
            end else if (st_q.flag) begin
                st_d.hold = HOLD_LOAD;
            end else begin
                st_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            st_q.flag <= 1'b0;
            st_q.hold <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign rst_o  = (st_q.hold != '0);

    AST_SECOND_STRIKE: assert property (@(posedge clk_i) disable iff (srst_i)
        $rose(rst_o) |-> $past(expire_i && flag_o && !aclr_i));  // R4
    AST_FIRST_STRIKE: assert property (@(posedge clk_i) disable iff (srst_i)
        (expire_i && !aclr_i && !flag_o) |=> (flag_o && !rst_o));  // R3
    AST_AUTOCLR: assert property (@(posedge clk_i) disable iff (srst_i)
        (expire_i && aclr_i) |=> !flag_o);  // R7
    AST_HOLD_BOUND: assert property (@(posedge clk_i) disable iff (srst_i)
        st_q.hold <= HOLD_LOAD);  // R4
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
    import wdt2_pkg::*;
#(
    parameter int PERIOD_W = 10,
    parameter logic [PERIOD_W-1:0] DEF_PERIOD = 20,
    parameter int RST_HOLD = 8,
    parameter logic ACLR_INIT = 1'b1
) (
    input  logic              clk_i,
    input  logic              srst_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              tick_i,
    output logic              sys_rst_o
);
    logic [PERIOD_W-1:0] count_w;
    logic [PERIOD_W-1:0] period_w;
    logic                flag_w;
    logic                aclr_w;
    logic                kick_w;
    logic                clear_w;
    logic                expire_w;

    wdt2_regs #(
        .PERIOD_W  (PERIOD_W),
        .DEF_PERIOD(DEF_PERIOD),
        .ACLR_INIT (ACLR_INIT)
    ) regs_i (
        .clk_i   (clk_i),
        .srst_i  (srst_i),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .count_i (count_w),
        .flag_i  (flag_w),
        .rdata_o (reg_rdata_o),
        .period_o(period_w),
        .aclr_o  (aclr_w),
        .kick_o  (kick_w),
        .clear_o (clear_w)
    );

    wdt2_counter #(
        .PERIOD_W  (PERIOD_W),
        .DEF_PERIOD(DEF_PERIOD)
    ) cnt_i (
        .clk_i   (clk_i),
        .srst_i  (srst_i),
        .tick_i  (tick_i),
        .reload_i(kick_w),
        .period_i(period_w),
        .count_o (count_w),
        .expire_o(expire_w)
    );

    wdt2_strike #(
        .RST_HOLD(RST_HOLD)
    ) strike_i (
        .clk_i   (clk_i),
        .srst_i  (srst_i),
        .expire_i(expire_w),
        .aclr_i  (aclr_w),
        .clear_i (clear_w),
        .flag_o  (flag_w),
        .rst_o   (sys_rst_o)
    );

    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (srst_i)
        (reg_wr_i && reg_addr_i == OFS_STAT && reg_wdata_i[FLAG_BIT] && !tick_i)
        |=> !flag_w);  // R5
    AST_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (srst_i)
        (reg_wr_i && reg_addr_i == OFS_KICK) |=> (!flag_w && count_w == $past(period_w)));  // R6
endmodule

// File: tb/wdt2_top_tb_top.sv
`timescale 1ns/1ps
module wdt2_top_tb_top;
    localparam int RST_HOLD = 8;
    localparam logic [1:0] K_WR   = 2'd0;
    localparam logic [1:0] K_TICK = 2'd1;

    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  addr;
        logic [15:0] data;
        logic        ef;
        logic        er;
    } vec_t;

    // disarm auto-clear, period 3, kick, then two strikes
    localparam vec_t VEC [9] = '{
        '{K_WR,   4'h8, 16'h0000, 1'b0, 1'b0},
        '{K_WR,   4'hC, 16'h0003, 1'b0, 1'b0},
        '{K_WR,   4'h0, 16'h0000, 1'b0, 1'b0},
        '{K_TICK, 4'h0, 16'h0000, 1'b0, 1'b0},
        '{K_TICK, 4'h0, 16'h0000, 1'b0, 1'b0},
        '{K_TICK, 4'h0, 16'h0000, 1'b1, 1'b0},
        '{K_TICK, 4'h0, 16'h0000, 1'b1, 1'b0},
        '{K_TICK, 4'h0, 16'h0000, 1'b1, 1'b0},
        '{K_TICK, 4'h0, 16'h0000, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic        wr = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        tick = 1'b0;
    logic        sys_rst;
    int          n_run = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    wdt2_top dut_i (
        .clk_i      (clk),
        .srst_i     (srst),
        .reg_wr_i   (wr),
        .reg_addr_i (addr),
        .reg_wdata_i(wdata),
        .reg_rdata_o(rdata),
        .tick_i     (tick),
        .sys_rst_o  (sys_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [3:0] a, input logic [15:0] d, input logic t);
        @(negedge clk);
        wr = w; addr = a; wdata = d; tick = t;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic rd_flag(output int v);
        int s;
        rd(4'h4, s);
        v = (s >> 3) & 1;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v;
        int f;
        int hold_len;
        repeat (3) @(negedge clk);
        srst = 1'b0;
        // R1 reset state
        rd_flag(f);        check("R1 flag", f, 0);
        check("R1 rst", int'(sys_rst), 0);
        rd(4'h8, v);       check("R1 ctrl", v, 16'h2000);
        rd(4'hC, v);       check("R1 period", v, 20);
        rd(4'h0, v);       check("R1 count", v, 20);

        foreach (VEC[i]) begin
            step(VEC[i].kind == K_WR, VEC[i].addr, VEC[i].data, VEC[i].kind == K_TICK);
            rd_flag(f);
            check($sformatf("R3/R4 vec%0d flag", i), f, int'(VEC[i].ef));
            check($sformatf("R4 vec%0d rst", i), int'(sys_rst), int'(VEC[i].er));
        end

        // R4 hold length
        hold_len = 1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sys_rst) hold_len++;
        end
        check("R4 hold length", hold_len, RST_HOLD);

        // R5 write 0 to bit 3 keeps flag, write 1 clears
        step(1'b1, 4'h4, 16'h0000, 1'b0);
        rd_flag(f);        check("R5 zero write", f, 1);
        step(1'b1, 4'h4, 16'h0008, 1'b0);
        rd_flag(f);        check("R5 w1c", f, 0);

        // R2 counting, then set flag again
        rd(4'h0, v);       check("R2 count start", v, 3);
        step(1'b0, 4'h0, 16'h0, 1'b0);
        rd(4'h0, v);       check("R2 idle", v, 3);
        step(1'b0, 4'h0, 16'h0, 1'b1);
        rd(4'h0, v);       check("R2 dec", v, 2);
        step(1'b0, 4'h0, 16'h0, 1'b1);
        step(1'b0, 4'h0, 16'h0, 1'b1);
        rd_flag(f);        check("R3 flag set", f, 1);
        rd(4'h0, v);       check("R3 reload", v, 3);
        step(1'b0, 4'h0, 16'h0, 1'b1);
        step(1'b0, 4'h0, 16'h0, 1'b1);
        // R6 keepalive together with final tick
        step(1'b1, 4'h0, 16'h0, 1'b1);
        rd_flag(f);        check("R6 flag cleared", f, 0);
        rd(4'h0, v);       check("R6 reload", v, 3);
        check("R6 no reset", int'(sys_rst), 0);

        // R8 period change at next reload
        step(1'b1, 4'hC, 16'h0005, 1'b0);
        step(1'b0, 4'h0, 16'h0, 1'b1);
        rd(4'h0, v);       check("R8 running count", v, 2);
        step(1'b0, 4'h0, 16'h0, 1'b1);
        step(1'b0, 4'h0, 16'h0, 1'b1);
        rd(4'h0, v);       check("R8 new period", v, 5);
        rd_flag(f);        check("R8 flag", f, 1);

        // R7 auto-clear absorbs expiries
        step(1'b1, 4'h8, 16'h2000, 1'b0);
        v = 0;
        for (int k = 0; k < 15; k++) begin
            step(1'b0, 4'h0, 16'h0, 1'b1);
            if (sys_rst) v++;
        end
        check("R7 no reset", v, 0);
        rd_flag(f);        check("R7 flag clear", f, 0);

        // R1 reset again
        step(1'b1, 4'h8, 16'h0000, 1'b0);
        @(negedge clk); srst = 1'b1;
        @(negedge clk); srst = 1'b0;
        rd(4'h8, v);       check("R1 ctrl again", v, 16'h2000);
        rd(4'hC, v);       check("R1 period again", v, 20);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule